// File: doc/BRIEF.md
# Two-Port Synchronous RAM with Per-Port Output Mode

This block is a synchronous memory shared by two fully independent ports. Each port has its own clock, address, write data, read data, a read/write control, a pair of chip enables (one active low, one active high), an asynchronous output enable and an output-mode select. Either port can read or write any word in any of its cycles, including the word the other port is using at that moment.

Every control, address and data input is captured on the rising edge of the port's own clock. The mode select picks between two read paths. In flow-through mode the read word is available right after the edge that captured the address. In registered mode it passes through one more output stage and appears one edge later. A port that is deselected, or that is writing, does not drive its read bus. The read bus is modelled as a data word plus a valid flag: when the flag is low the word reads zero and stands for a released (high-impedance) bus.

Storage uses a live-value-table arrangement: one bank per port, with a pair of per-word marker bits recording which bank holds the newest value. Each storage element therefore has exactly one writing clock domain.

Top module: `dual_clock_ram`

## Requirements
- R1: A port is selected at an edge only when its active-low enable is 0 and its active-high enable is 1. At an edge where it is not selected, a write does not change memory and no read is started.
- R2: At a selected edge, the read/write input at 0 writes the write-data word to the addressed location, and at 1 reads that location.
- R3: With the mode input at 0 (flow-through), the data and a high valid flag of a read appear after the same edge that captured the read, and remain until the next edge.
- R4: With the mode input at 1 (registered), the data and a high valid flag of a read appear after the edge following the one that captured the read.
- R5: A cycle in which a port is deselected or writes takes the valid flag low after one edge in flow-through mode and after two edges in registered mode. After a deselected cycle in registered mode, the first selected read edge is followed by a cycle with the flag still low.
- R6: The active-low output enable acts without a clock. While it is 1, the valid flag is 0, and whenever the valid flag is 0 the read data is all zeros.
- R7: A word written by one port is returned by a read on the other port captured at a later edge. A read captured at an earlier edge returns the previous contents. If both ports write the same word at the same edge, the stored value is undefined.
- R8: After the reset input (active low) is released, both valid flags are 0 until a read is captured.
- R9: The two ports can access different words in overlapping cycles without disturbing each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset of the control state on both ports |
| a_clk | input | 1 | Port A clock |
| a_en_n | input | 1 | Port A enable, active low |
| a_en | input | 1 | Port A enable, active high |
| a_rd | input | 1 | Port A read (1) or write (0) |
| a_pipe | input | 1 | Port A output mode: 0 flow-through, 1 registered |
| a_oe_n | input | 1 | Port A asynchronous output enable, active low |
| a_addr | input | AW | Port A word address |
| a_wdata | input | DW | Port A write data |
| a_rdata | output | DW | Port A read data, zero when not valid |
| a_valid | output | 1 | Port A read bus driven |
| b_clk | input | 1 | Port B clock |
| b_en_n | input | 1 | Port B enable, active low |
| b_en | input | 1 | Port B enable, active high |
| b_rd | input | 1 | Port B read (1) or write (0) |
| b_pipe | input | 1 | Port B output mode: 0 flow-through, 1 registered |
| b_oe_n | input | 1 | Port B asynchronous output enable, active low |
| b_addr | input | AW | Port B word address |
| b_wdata | input | DW | Port B write data |
| b_rdata | output | DW | Port B read data, zero when not valid |
| b_valid | output | 1 | Port B read bus driven |

## Verification
The bench builds the block with its defaults: a 6-bit address (64 words) and a 9-bit word. With these values the top address 63 and the all-ones word 0x1FF can be reached in a few cycles. Port A runs in flow-through mode and port B in registered mode. The two clocks share a period and are offset by half of it, so each cross-port case has a clear earlier or later edge. The old-versus-new read rule is then checked in both directions.

// File: rtl/dual_clock_ram.sv
module dual_clock_ram #(
  parameter int AW = 6,
  parameter int DW = 9
) (
  input  logic          rst_n,
  input  logic          a_clk,
  input  logic          a_en_n,
  input  logic          a_en,
  input  logic          a_rd,
  input  logic          a_pipe,
  input  logic          a_oe_n,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  output logic          a_valid,
  input  logic          b_clk,
  input  logic          b_en_n,
  input  logic          b_en,
  input  logic          b_rd,
  input  logic          b_pipe,
  input  logic          b_oe_n,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata,
  output logic          b_valid
);
  localparam int DEPTH = 1 << AW;

  // one bank per port; marker pair selects the newest bank per word
  logic [DW-1:0] bank_a [DEPTH];
  logic [DW-1:0] bank_b [DEPTH];
  logic [DEPTH-1:0] mark_a, mark_b;

  wire a_sel = ~a_en_n & a_en;
  wire b_sel = ~b_en_n & b_en;
  wire a_wr  = a_sel & ~a_rd;
  wire b_wr  = b_sel & ~b_rd;

  wire [DW-1:0] a_word = (mark_a[a_addr] ^ mark_b[a_addr]) ? bank_a[a_addr] : bank_b[a_addr];
  wire [DW-1:0] b_word = (mark_a[b_addr] ^ mark_b[b_addr]) ? bank_a[b_addr] : bank_b[b_addr];

  // ---------------- port A ----------------
  logic          a_act1, a_act2, a_mode;
  logic [DW-1:0] a_q1, a_q2;

  always_ff @(posedge a_clk)
    if (a_wr) bank_a[a_addr] <= a_wdata;

  always_ff @(posedge a_clk or negedge rst_n)
    if (!rst_n) begin
      mark_a <= '0;
      a_act1 <= 1'b0;
      a_act2 <= 1'b0;
      a_mode <= 1'b0;
      a_q1   <= '0;
      a_q2   <= '0;
    end else begin
      if (a_wr) mark_a[a_addr] <= ~mark_b[a_addr];
      a_act1 <= a_sel & a_rd;
      a_act2 <= a_act1;
      a_mode <= a_pipe;
      if (a_sel & a_rd) a_q1 <= a_word;
      a_q2 <= a_q1;
    end

  assign a_valid = (a_mode ? a_act2 : a_act1) & ~a_oe_n;
  assign a_rdata = a_valid ? (a_mode ? a_q2 : a_q1) : '0;

  AST_A_FLOW_IDLE: assert property (@(posedge a_clk) disable iff (!rst_n)
    (!a_pipe && !(a_sel && a_rd)) |=> !a_valid); // R5
  AST_A_PIPE_IDLE: assert property (@(posedge a_clk) disable iff (!rst_n)
    (a_pipe && !(a_sel && a_rd)) ##1 a_pipe |=> !a_valid); // R5
  AST_A_OE_GATE: assert property (@(posedge a_clk) disable iff (!rst_n)
    a_valid |-> !a_oe_n); // R6
  AST_A_FLOW_READ: assert property (@(posedge a_clk) disable iff (!rst_n)
    (!a_pipe && a_sel && a_rd && !a_oe_n) ##1 !a_oe_n |-> a_valid); // R3

  // ---------------- port B ----------------
  logic          b_act1, b_act2, b_mode;
  logic [DW-1:0] b_q1, b_q2;

  always_ff @(posedge b_clk)
    if (b_wr) bank_b[b_addr] <= b_wdata;

  always_ff @(posedge b_clk or negedge rst_n)
    if (!rst_n) begin
      mark_b <= '0;
      b_act1 <= 1'b0;
      b_act2 <= 1'b0;
      b_mode <= 1'b0;
      b_q1   <= '0;
      b_q2   <= '0;
    end else begin
      if (b_wr) mark_b[b_addr] <= mark_a[b_addr];
      b_act1 <= b_sel & b_rd;
      b_act2 <= b_act1;
      b_mode <= b_pipe;
      if (b_sel & b_rd) b_q1 <= b_word;
      b_q2 <= b_q1;
    end

  assign b_valid = (b_mode ? b_act2 : b_act1) & ~b_oe_n;
  assign b_rdata = b_valid ? (b_mode ? b_q2 : b_q1) : '0;

  AST_B_FLOW_IDLE: assert property (@(posedge b_clk) disable iff (!rst_n)
    (!b_pipe && !(b_sel && b_rd)) |=> !b_valid); // R5
  AST_B_PIPE_IDLE: assert property (@(posedge b_clk) disable iff (!rst_n)
    (b_pipe && !(b_sel && b_rd)) ##1 b_pipe |=> !b_valid); // R5
  AST_B_OE_GATE: assert property (@(posedge b_clk) disable iff (!rst_n)
    b_valid |-> !b_oe_n); // R6
  AST_B_PIPE_READ: assert property (@(posedge b_clk) disable iff (!rst_n)
    (b_pipe && b_sel && b_rd) ##1 b_pipe ##1 !b_oe_n |-> b_valid); // R4

endmodule

// File: tb/dual_clock_ram_test.sv
`timescale 1ns/100ps
module dual_clock_ram_test;
  logic rst_n = 1'b0;
  logic a_clk = 1'b0, b_clk = 1'b0;
  logic a_en_n = 1'b1, a_en = 1'b0, a_rd = 1'b1, a_pipe = 1'b0, a_oe_n = 1'b0;
  logic b_en_n = 1'b1, b_en = 1'b0, b_rd = 1'b1, b_pipe = 1'b1, b_oe_n = 1'b0;
  logic [5:0] a_addr = '0, b_addr = '0;
  logic [8:0] a_wdata = '0, b_wdata = '0;
  logic [8:0] a_rdata, b_rdata;
  logic a_valid, b_valid;
  int checks = 0, fails = 0;

  dual_clock_ram #(.AW(6), .DW(9)) uut (
    .rst_n(rst_n),
    .a_clk(a_clk), .a_en_n(a_en_n), .a_en(a_en), .a_rd(a_rd), .a_pipe(a_pipe),
    .a_oe_n(a_oe_n), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata), .a_valid(a_valid),
    .b_clk(b_clk), .b_en_n(b_en_n), .b_en(b_en), .b_rd(b_rd), .b_pipe(b_pipe),
    .b_oe_n(b_oe_n), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata), .b_valid(b_valid)
  );

  always #2 a_clk = ~a_clk;
  initial begin
    #2;
    forever #2 b_clk = ~b_clk;
  end

  // {en_n, en, rd, addr[5:0], wdata[8:0], exp_valid, exp_data[8:0]} for port A, flow-through
  localparam logic [27:0] VEC [9] = '{
    {1'b0, 1'b1, 1'b0, 6'd5,  9'h1AA, 1'b0, 9'h000},
    {1'b0, 1'b1, 1'b0, 6'd6,  9'h055, 1'b0, 9'h000},
    {1'b0, 1'b1, 1'b1, 6'd5,  9'h000, 1'b1, 9'h1AA},
    {1'b0, 1'b1, 1'b1, 6'd6,  9'h000, 1'b1, 9'h055},
    {1'b1, 1'b1, 1'b0, 6'd5,  9'h000, 1'b0, 9'h000},
    {1'b0, 1'b1, 1'b1, 6'd5,  9'h000, 1'b1, 9'h1AA},
    {1'b0, 1'b0, 1'b1, 6'd6,  9'h000, 1'b0, 9'h000},
    {1'b0, 1'b1, 1'b0, 6'd63, 9'h1FF, 1'b0, 9'h000},
    {1'b0, 1'b1, 1'b1, 6'd63, 9'h000, 1'b1, 9'h1FF}
  };
  localparam string VREQ [9] = '{"R2", "R2", "R3", "R3", "R1", "R1", "R1", "R5", "R3"};

  task automatic chk(input string req, input logic v, input logic [8:0] d,
                     input logic ev, input logic [8:0] ed);
    logic [8:0] want;
    want = ev ? ed : 9'h000;
    checks++;
    if (v !== ev || d !== want) begin
      fails++;
      $display("FAIL %s: valid=%b data=%h expected valid=%b data=%h", req, v, d, ev, want);
    end
  endtask

  task automatic a_drive(input logic en_n, input logic en, input logic rd,
                         input logic [5:0] ad, input logic [8:0] wd);
    a_en_n = en_n; a_en = en; a_rd = rd; a_addr = ad; a_wdata = wd;
  endtask

  task automatic b_drive(input logic en_n, input logic en, input logic rd,
                         input logic [5:0] ad, input logic [8:0] wd);
    b_en_n = en_n; b_en = en; b_rd = rd; b_addr = ad; b_wdata = wd;
  endtask

  task automatic a_step(input logic en_n, input logic en, input logic rd,
                        input logic [5:0] ad, input logic [8:0] wd);
    a_drive(en_n, en, rd, ad, wd);
    @(posedge a_clk); #1;
  endtask

  task automatic b_step(input logic en_n, input logic en, input logic rd,
                        input logic [5:0] ad, input logic [8:0] wd);
    b_drive(en_n, en, rd, ad, wd);
    @(posedge b_clk); #1;
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: valid=x data=x expected valid=done data=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge a_clk);
    #1 rst_n = 1'b1;
    // R8: nothing captured yet
    chk("R8", a_valid, a_rdata, 1'b0, 9'h000);
    chk("R8", b_valid, b_rdata, 1'b0, 9'h000);

    for (int i = 0; i < 9; i++) begin
      a_step(VEC[i][27], VEC[i][26], VEC[i][25], VEC[i][24:19], VEC[i][18:10]);
      chk(VREQ[i], a_valid, a_rdata, VEC[i][9], VEC[i][8:0]);
    end
    a_step(1'b1, 1'b0, 1'b1, 6'd0, 9'h000);

    // R4/R5 port B registered mode
    b_step(1'b0, 1'b1, 1'b1, 6'd5, 9'h000);
    chk("R5", b_valid, b_rdata, 1'b0, 9'h000);
    b_step(1'b1, 1'b0, 1'b1, 6'd0, 9'h000);
    chk("R4", b_valid, b_rdata, 1'b1, 9'h1AA);
    b_step(1'b1, 1'b0, 1'b1, 6'd0, 9'h000);
    chk("R5", b_valid, b_rdata, 1'b0, 9'h000);
    b_step(1'b0, 1'b1, 1'b1, 6'd6, 9'h000);
    chk("R5", b_valid, b_rdata, 1'b0, 9'h000);
    b_step(1'b0, 1'b1, 1'b0, 6'd7, 9'h0C3);
    chk("R4", b_valid, b_rdata, 1'b1, 9'h055);
    b_step(1'b0, 1'b1, 1'b1, 6'd7, 9'h000);
    chk("R5", b_valid, b_rdata, 1'b0, 9'h000);
    b_step(1'b1, 1'b0, 1'b1, 6'd0, 9'h000);
    chk("R2", b_valid, b_rdata, 1'b1, 9'h0C3);

    // R7 cross-port ordering
    a_step(1'b0, 1'b1, 1'b0, 6'd10, 9'h0F0);
    chk("R7", a_valid, a_rdata, 1'b0, 9'h000);
    @(posedge b_clk); #1;
    b_drive(1'b0, 1'b1, 1'b0, 6'd10, 9'h123);
    a_drive(1'b0, 1'b1, 1'b1, 6'd10, 9'h000);
    @(posedge a_clk); #1;
    chk("R7", a_valid, a_rdata, 1'b1, 9'h0F0);
    @(posedge b_clk); #1;
    b_drive(1'b1, 1'b0, 1'b1, 6'd0, 9'h000);
    a_step(1'b0, 1'b1, 1'b1, 6'd10, 9'h000);
    chk("R7", a_valid, a_rdata, 1'b1, 9'h123);

    // R9 overlapping accesses on different words
    a_drive(1'b0, 1'b1, 1'b0, 6'd20, 9'h0AB);
    b_drive(1'b0, 1'b1, 1'b0, 6'd21, 9'h154);
    @(posedge a_clk);
    @(posedge b_clk); #1;
    a_drive(1'b0, 1'b1, 1'b1, 6'd21, 9'h000);
    b_drive(1'b0, 1'b1, 1'b1, 6'd20, 9'h000);
    @(posedge a_clk); #1;
    chk("R9", a_valid, a_rdata, 1'b1, 9'h154);
    @(posedge b_clk); #1;
    b_drive(1'b1, 1'b0, 1'b1, 6'd0, 9'h000);
    @(posedge b_clk); #1;
    chk("R9", b_valid, b_rdata, 1'b1, 9'h0AB);

    // R6 asynchronous output enable, between edges
    @(posedge a_clk); #1;
    a_oe_n = 1'b1;
    #0.5;
    chk("R6", a_valid, a_rdata, 1'b0, 9'h000);
    a_oe_n = 1'b0;
    #0.5;
    chk("R6", a_valid, a_rdata, 1'b1, 9'h154);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule